// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller

This block gathers eleven peripheral request lines into one interrupt request for a processor. It samples every line on each clock and watches for a low-to-high transition. When it sees one, it sets the matching bit in a pending register, and that bit stays set until software acknowledges it. A separate enable register chooses which pending bits can reach the processor. The request output is a registered OR over all bits that are both pending and enabled.

Software uses a small register port with separate read and write strobes, a word offset and 32-bit data. The pending register sits at offset 0x00 and the enable register at offset 0x04. An acknowledge write ANDs the data into the pending register, so a 1 keeps a bit and a 0 clears it. Any other offset reads as all ones, and writes to it are dropped.

The port has no back-pressure. It accepts a strobe on every cycle. Read data appears one cycle after the read strobe, together with a one-cycle valid flag, and the source never has to wait.

The eleven sources map to bits in this order, bit 0 first: vertical blank, graphics, optical drive, DMA, timer 0, timer 1, timer 2, controller port, serial port, sound, spare.

Top module: `irqc_top`

## Requirements
- R1: A synchronous active-high reset clears the pending register, the enable register, the request output and the stored previous line levels. A line that is already high when reset is released therefore counts as a rising edge on the first clock after release.
- R2: A line that is sampled high on a clock edge, after being sampled low on the edge before, sets its pending bit on that edge. Bit i belongs to line i, in the order given above.
- R3: A line held high sets its pending bit only once, so after an acknowledge the bit stays clear. A falling edge never sets or clears a pending bit.
- R4: A write at offset 0x00 replaces the pending register with its current value ANDed with the low 11 data bits. A data bit of 0 clears the matching bit and a data bit of 1 leaves it unchanged.
- R5: A write at offset 0x04 loads the low 11 data bits into the enable register. Bits 31..11 read back as zero.
- R6: The request output is registered. On each clock edge it takes the value of (pending AND enable) != 0 as that value stood before the edge, so it changes one edge after the pending or enable bit that causes the change.
- R7: A read at offset 0x00 returns the pending register and a read at offset 0x04 returns the enable register, with bits 31..11 zero in both. Read data and a one-cycle valid flag appear on the edge after the read strobe.
- R8: A read at any offset other than 0x00 and 0x04 returns 0xFFFFFFFF.
- R9: A write at any offset other than 0x00 and 0x04 leaves the pending and enable registers unchanged.
- R10: If a rising edge and an acknowledge write that clears the same bit fall on the same clock edge, the edge wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 11 | Peripheral request lines, synchronous to clk_i |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| offset_i | input | 8 | Byte offset of the addressed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | High for one cycle when rdata_o holds a fresh read result |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The properties assume that the request lines are already synchronous to the clock and that each line stays stable for a whole cycle. They also assume that one strobe names one offset, with a write and a read never presented together. The bench drives the lines, strobes, offsets and data only on the falling clock edge, and it raises at most one strobe at a time, so every input is settled before the rising edge that samples it. It holds a line high through reset on purpose, to exercise the case where the stored previous level is cleared while the line is already high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned IRQC_NUM_SRC = 11;
  localparam int unsigned IRQC_DATA_W  = 32;
  localparam int unsigned IRQC_OFF_W   = 8;

  localparam int unsigned IRQC_OFF_PEND = 0;
  localparam int unsigned IRQC_OFF_ENAB = 4;

  // Bit position of every source in the pending and enable registers.
  typedef enum int unsigned {
    SRC_VBLANK  = 0,
    SRC_GFX     = 1,
    SRC_OPTICAL = 2,
    SRC_DMA     = 3,
    SRC_TIMER0  = 4,
    SRC_TIMER1  = 5,
    SRC_TIMER2  = 6,
    SRC_CTRLPAD = 7,
    SRC_SERIAL  = 8,
    SRC_SOUND   = 9,
    SRC_SPARE   = 10
  } irqc_src_e;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_ENAB = 2'd1,
    SEL_NONE = 2'd2
  } irqc_sel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned OFF_W = IRQC_OFF_W
) (
  input  logic [OFF_W-1:0] offset_i,
  output irqc_sel_e        sel_o
);

  localparam logic [OFF_W-1:0] PendOff = OFF_W'(IRQC_OFF_PEND);
  localparam logic [OFF_W-1:0] EnabOff = OFF_W'(IRQC_OFF_ENAB);

  always_comb begin
    if (offset_i == PendOff)      sel_o = SEL_PEND;
    else if (offset_i == EnabOff) sel_o = SEL_ENAB;
    else                          sel_o = SEL_NONE;
  end

endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] line_i,
  output logic [NUM_SRC-1:0] prev_o,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] prev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    always_ff @(posedge clk_i) begin
      if (rst_i) prev_q[g] <= 1'b0;
      else       prev_q[g] <= line_i[g];
    end
    assign rise_o[g] = line_i[g] & ~prev_q[g];
  end

  assign prev_o = prev_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  irqc_sel_e          sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] enab_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);

  localparam int unsigned PadW = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] enab_q, enab_d;
  logic [NUM_SRC-1:0] wbits;
  logic [DATA_W-1:0]  rmux;

  assign wbits = wdata_i[NUM_SRC-1:0];

  // Acknowledge first, then OR in new edges so an edge is never lost.
  always_comb begin
    pend_d = pend_q;
    if (wr_en_i && sel_i == SEL_PEND) pend_d = pend_q & wbits;
    pend_d = pend_d | rise_i;
  end

  always_comb begin
    enab_d = enab_q;
    if (wr_en_i && sel_i == SEL_ENAB) enab_d = wbits;
  end

  always_comb begin
    case (sel_i)
      SEL_PEND: rmux = {{PadW{1'b0}}, pend_q};
      SEL_ENAB: rmux = {{PadW{1'b0}}, enab_q};
      default:  rmux = {DATA_W{1'b1}};
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q   <= '0;
      enab_q   <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      enab_q   <= enab_d;
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rmux;
    end
  end

  assign pend_o = pend_q;
  assign enab_o = enab_q;

endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] enab_i,
  output logic               irq_o
);

  logic hit;

  assign hit = |(pend_i & enab_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= hit;
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQC_NUM_SRC,
  parameter int unsigned DATA_W  = IRQC_DATA_W,
  parameter int unsigned OFF_W   = IRQC_OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] line_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [OFF_W-1:0]   offset_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               irq_o
);

  irqc_sel_e          sel;
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] enab_q;

  irqc_decode #(.OFF_W(OFF_W)) u_decode (
    .offset_i (offset_i),
    .sel_o    (sel)
  );

  irqc_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .line_i (line_i),
    .prev_o (prev_q),
    .rise_o (rise)
  );

  irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rise_i   (rise),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .pend_o   (pend_q),
    .enab_o   (enab_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  irqc_req #(.NUM_SRC(NUM_SRC)) u_req (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pend_i (pend_q),
    .enab_i (enab_q),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQC_NUM_SRC,
  parameter int unsigned DATA_W  = IRQC_DATA_W,
  parameter int unsigned OFF_W   = IRQC_OFF_W
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [NUM_SRC-1:0] prev_q,
  input logic [NUM_SRC-1:0] rise,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] enab_q,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [OFF_W-1:0]   offset_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               rvalid_o,
  input logic               irq_o
);

  localparam logic [OFF_W-1:0] PendOff = OFF_W'(IRQC_OFF_PEND);
  localparam logic [OFF_W-1:0] EnabOff = OFF_W'(IRQC_OFF_ENAB);
  localparam int unsigned PadW = DATA_W - NUM_SRC;

  logic bad_off;
  assign bad_off = (offset_i != PendOff) && (offset_i != EnabOff);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    assert_rise_sets_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      rise[g] |=> pend_q[g]);

    assert_no_spurious_set_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pend_q[g] && !rise[g]) |=> !pend_q[g]);

    assert_edge_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (rise[g] && wr_en_i && offset_i == PendOff && !wdata_i[g]) |=> pend_q[g]);
  end

  assert_ack_and_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && offset_i == PendOff) |=>
      pend_q == (($past(pend_q) & $past(wdata_i[NUM_SRC-1:0])) | $past(rise)));

  assert_enable_load_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && offset_i == EnabOff) |=> enab_q == $past(wdata_i[NUM_SRC-1:0]));

  assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> irq_o == $past(|(pend_q & enab_q)));

  assert_read_pend_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && offset_i == PendOff) |=>
      (rvalid_o && rdata_o == {{PadW{1'b0}}, $past(pend_q)}));

  assert_bad_read_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && bad_off) |=> (rvalid_o && rdata_o == {DATA_W{1'b1}}));

  assert_bad_write_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && bad_off) |=> enab_q == $past(enab_q));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (pend_q == '0 && enab_q == '0 && prev_q == '0 && !irq_o));

endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .prev_q   (prev_q),
  .rise     (rise),
  .pend_q   (pend_q),
  .enab_q   (enab_q),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .offset_i (offset_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .irq_o    (irq_o)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  import irqc_pkg::*;

  localparam int N = IRQC_NUM_SRC;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  line;
  logic          wr_en, rd_en;
  logic [7:0]    offset;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irqc_top uut (
    .clk_i (clk), .rst_i (rst), .line_i (line),
    .wr_en_i (wr_en), .rd_en_i (rd_en), .offset_i (offset),
    .wdata_i (wdata), .rdata_o (rdata), .rvalid_o (rvalid), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] val);
    rd_en = 1'b1; offset = off;
    step();
    rd_en = 1'b0;
    chk("R7 rvalid", {31'd0, rvalid}, 32'd1);
    val = rdata;
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] val);
    wr_en = 1'b1; offset = off; wdata = val;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst = 1'b1; line = '0; line[SRC_VBLANK] = 1'b1;
    wr_en = 0; rd_en = 0; offset = 0; wdata = 0;
    step(); step();
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    step(); // line still high, stored level was cleared: edge seen here
    rd(8'h04, v); chk("R1 enable after reset", v, 32'h0);
    rd(8'h00, v); chk("R1 line high at release latches", v, 32'h1);
    wr(8'h00, 32'h0);
    line = '0; step();
    rd(8'h00, v); chk("R1 pending cleared", v, 32'h0);
  endtask

  task automatic t_each_line();
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      line[i] = 1'b1; step();
      rd(8'h00, v); chk("R2 rising edge sets its own bit", v, 32'(1) << i);
      line[i] = 1'b0;
      wr(8'h00, ~(32'(1) << i));
    end
    rd(8'h00, v); chk("R2 all acknowledged", v, 32'h0);
  endtask

  task automatic t_held_and_fall();
    logic [31:0] v;
    line[SRC_SOUND] = 1'b1; step();
    wr(8'h00, 32'h0);
    step(); step();
    rd(8'h00, v); chk("R3 held high does not re-set", v, 32'h0);
    line[SRC_SOUND] = 1'b1; line[SRC_DMA] = 1'b1; step();
    rd(8'h00, v); chk("R3 DMA set while sound held", v, 32'h8);
    line[SRC_DMA] = 1'b0; line[SRC_SOUND] = 1'b0; step();
    rd(8'h00, v); chk("R3 falling edge does not clear", v, 32'h8);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R3 falling edge does not set", v, 32'h0);
  endtask

  task automatic t_ack_and();
    logic [31:0] v;
    line = 11'h5A5; step(); line = '0; step();
    rd(8'h00, v); chk("R4 pattern latched", v, 32'h5A5);
    wr(8'h00, 32'hFFFF_F0F0);
    rd(8'h00, v); chk("R4 AND acknowledge", v, 32'h0A0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R4 ones keep bits", v, 32'h0A0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R5 upper bits read zero", v, 32'h7FF);
    wr(8'h04, 32'h0000_0212);
    rd(8'h04, v); chk("R5 enable loaded", v, 32'h212);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_irq();
    wr(8'h04, 32'(1) << SRC_TIMER1);
    line[SRC_TIMER0] = 1'b1; step(); step();
    chk("R6 disabled source gives no irq", {31'd0, irq}, 32'd0);
    line[SRC_TIMER1] = 1'b1; step();
    chk("R6 irq one edge late", {31'd0, irq}, 32'd0);
    step();
    chk("R6 irq raised", {31'd0, irq}, 32'd1);
    line = '0;
    wr(8'h00, ~(32'(1) << SRC_TIMER1));
    chk("R6 irq holds for one edge after ack", {31'd0, irq}, 32'd1);
    step();
    chk("R6 irq dropped", {31'd0, irq}, 32'd0);
    wr(8'h04, 32'(1) << SRC_TIMER0);
    step();
    chk("R6 irq on enabling pending bit", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); step();
    chk("R6 irq clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_bad_offsets();
    logic [31:0] v;
    rd(8'h08, v); chk("R8 read 0x08", v, 32'hFFFF_FFFF);
    rd(8'h01, v); chk("R8 read 0x01", v, 32'hFFFF_FFFF);
    rd(8'hFC, v); chk("R8 read 0xFC", v, 32'hFFFF_FFFF);
    line[SRC_SPARE] = 1'b1; step(); line = '0;
    wr(8'h05, 32'h7FF);
    wr(8'h0C, 32'h0);
    rd(8'h04, v); chk("R9 enable untouched", v, 32'h0);
    rd(8'h00, v); chk("R9 pending untouched", v, 32'h400);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    line[SRC_SERIAL] = 1'b1; step(); line[SRC_SERIAL] = 1'b0; step();
    line[SRC_SERIAL] = 1'b1;
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R10 edge beats acknowledge", v, 32'h100);
    line = '0;
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R10 later acknowledge clears", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_each_line();
    t_held_and_fall();
    t_ack_and();
    t_enable();
    t_irq();
    t_bad_offsets();
    t_collision();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule